// File: doc/BRIEF.md
# SPI Slave Receive Slot Ring

This block is the receive side of an SPI slave. It takes mode 0 serial words framed by an active-low chip select and writes each complete word into a window of receive slots. The window is set by a start index and an end index, and a single current-slot pointer runs from the start index to the end index. Each slot carries its own empty flag. When the end slot is written, the pointer returns to the start index and a group-complete interrupt flag is set.

A word that reaches a slot holding unread data still overwrites that slot, and a sticky overrun flag is raised. With one-shot mode off, the ring keeps going past completion. With one-shot mode on, the group turns itself off after the end slot is filled, and any further word is discarded. The pointer only goes back to the start index when software disables the group, reconfigures it and enables it again.

A small CPU register port configures the group, reads slots (each read marks the slot empty again) and clears the two flags by writing ones. The serial pins are oversampled in the system clock domain. Each finished word produces a single-cycle internal write strobe.

Top module: `spi_rx_group`

## Requirements
- R1: After reset, CTRL (register select 0) reads 0, STAT (register select 1) reads 0, EMPTY (register select 2) has every slot bit set to 1, and both interrupt outputs are low.
- R2: Bits are sampled on rising SCLK while cs_ni is low, most significant bit first. A word is stored once WORD_W bits have been sampled.
- R3: After each stored word the pointer moves to the next slot. After the end slot is written it returns to the start index.
- R4: Storing a word clears the EMPTY bit of its slot. A CPU read of that slot (reg_addr_i MSB set, low bits are the slot index) sets the bit again.
- R5: Writing the end slot sets the complete flag (STAT bit 0), which drives irq_done_o.
- R6: A word aimed at a slot whose EMPTY bit is 0 still overwrites the slot and sets the sticky overrun flag (STAT bit 1), which drives irq_ovr_o.
- R7: Writing STAT with bit 0 and/or bit 1 set clears the matching flag. Writing 0 to a bit leaves that flag unchanged.
- R8: With one-shot set (CTRL bit 1), filling the end slot clears the enable bit (CTRL bit 0). Later words are then discarded: no slot, EMPTY bit or flag changes.
- R9: While the group is disabled, incoming words are discarded and the pointer (STAT bits 4 and up) follows the start index. Enabling the group therefore begins at the start index.
- R10: If cs_ni rises before a word is complete, the partial bits are dropped, and the next frame starts a fresh word.
- R11: CTRL holds enable in bit 0, one-shot in bit 1, the start index at bit 4 and the end index at bit 8, and reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | SPI serial clock, mode 0 |
| cs_ni | input | 1 | Active-low chip select that frames a word |
| mosi_i | input | 1 | Serial data from the master |
| reg_addr_i | input | IDX_W+1 | MSB set: slot window; otherwise low two bits select CTRL, STAT or EMPTY |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (a slot read marks the slot empty) |
| reg_wdata_i | input | REG_W | Register write data |
| reg_rdata_o | output | REG_W | Combinational read data for reg_addr_i |
| irq_done_o | output | 1 | Group-complete flag |
| irq_ovr_o | output | 1 | Sticky receive overrun flag |

## Verification
A pointer that goes wrong shows up in the pointer field of STAT on the next CPU read. It also lands the following words in the wrong slots, so the slot data, the EMPTY map and the moment the complete flag rises all disagree with the expected sequence within one word time. A wrong EMPTY bit shows up as an overrun flag that is missing or false on the very next pass over that slot. A bit counter that is not cleared on an aborted frame shows up as a misaligned value in the next stored word. The stimulus runs past completion into a second pass and reads each slot afterwards, so each of these faults reaches the ports.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_STAT  = 2'd1,
    REG_EMPTY = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_EN_BIT    = 0;
  localparam int unsigned CTRL_OS_BIT    = 1;
  localparam int unsigned CTRL_START_LSB = 4;
  localparam int unsigned CTRL_END_LSB   = 8;
  localparam int unsigned STAT_DONE_BIT  = 0;
  localparam int unsigned STAT_OVR_BIT   = 1;
  localparam int unsigned STAT_PTR_LSB   = 4;
endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync #(
  parameter int unsigned     WIDTH   = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    logic [WIDTH-1:0] q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= RST_VAL;
        else         q <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= RST_VAL;
        else         q <= g_stg[s-1].q;
    end
  end

  assign q_o = g_stg[STAGES-1].q;
endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);

  logic [2:0]        pin_s;
  logic              sclk_s, cs_s, mosi_s, sclk_d;
  logic              sclk_rise;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] shreg;

  spi_rx_sync #(.WIDTH(3), .STAGES(STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, cs_ni, mosi_i}),
    .q_o   (pin_s)
  );

  assign {sclk_s, cs_s, mosi_s} = pin_s;
  assign sclk_rise = sclk_s & ~sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d     <= 1'b0;
      bit_cnt    <= '0;
      shreg      <= '0;
      word_o     <= '0;
      word_vld_o <= 1'b0;
    end else begin
      sclk_d     <= sclk_s;
      word_vld_o <= 1'b0;
      if (cs_s) begin
        // frame aborted or idle: drop partial word
        bit_cnt <= '0;
        shreg   <= '0;
      end else if (sclk_rise) begin
        shreg <= {shreg[WORD_W-2:0], mosi_s};
        if (bit_cnt == CNT_W'(WORD_W-1)) begin
          bit_cnt    <= '0;
          word_o     <= {shreg[WORD_W-2:0], mosi_s};
          word_vld_o <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_rx_slots.sv
module spi_rx_slots #(
  parameter int unsigned WORD_W    = 8,
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [IDX_W-1:0]  start_i,
  input  logic [IDX_W-1:0]  end_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic              clr_done_i,
  input  logic              clr_ovr_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [NUM_SLOTS-1:0] empty_o,
  output logic [IDX_W-1:0]  ptr_o,
  output logic              done_o,
  output logic              ovr_o,
  output logic              last_fill_o
);
  logic                              store;
  logic                              at_end;
  logic [IDX_W-1:0]                  ptr_nxt;
  logic [NUM_SLOTS-1:0][WORD_W-1:0]  data_flat;

  assign store       = wr_i & en_i;
  assign at_end      = (ptr_o == end_i);
  assign last_fill_o = store & at_end;
  assign ptr_nxt     = (ptr_o == IDX_W'(NUM_SLOTS-1)) ? '0 : ptr_o + 1'b1;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic [WORD_W-1:0] data_q;
    logic              empty_q;
    logic              hit_wr, hit_rd;

    assign hit_wr = store & (ptr_o == IDX_W'(g));
    assign hit_rd = rd_i & (rd_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q  <= '0;
        empty_q <= 1'b1;
      end else if (hit_wr) begin
        data_q  <= wdata_i;
        empty_q <= 1'b0;
      end else if (hit_rd) begin
        empty_q <= 1'b1;
      end
    end

    assign data_flat[g] = data_q;
    assign empty_o[g]   = empty_q;
  end

  assign rdata_o = data_flat[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o  <= '0;
      done_o <= 1'b0;
      ovr_o  <= 1'b0;
    end else begin
      if (!en_i)      ptr_o <= start_i;
      else if (store) ptr_o <= at_end ? start_i : ptr_nxt;

      if (last_fill_o)     done_o <= 1'b1;
      else if (clr_done_i) done_o <= 1'b0;

      if (store && !empty_o[ptr_o]) ovr_o <= 1'b1;
      else if (clr_ovr_i)           ovr_o <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_rx_group.sv
module spi_rx_group
  import spi_rx_pkg::*;
#(
  parameter int unsigned WORD_W    = 8,
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned REG_W     = 16,
  parameter int unsigned SYNC_STG  = 2,
  localparam int unsigned IDX_W    = $clog2(NUM_SLOTS),
  localparam int unsigned ADDR_W   = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_done_o,
  output logic              irq_ovr_o
);
  logic                 word_vld;
  logic [WORD_W-1:0]    word;
  logic                 grp_en, one_shot;
  logic [IDX_W-1:0]     start_idx, end_idx, cur_ptr;
  logic [NUM_SLOTS-1:0] empty_map;
  logic [WORD_W-1:0]    slot_rdata;
  logic                 last_fill;
  logic                 is_slot;
  reg_sel_e             reg_sel;
  logic                 ctrl_wr, stat_wr, slot_rd;
  logic                 unused_wdata;

  assign is_slot = reg_addr_i[ADDR_W-1];
  assign reg_sel = reg_sel_e'(reg_addr_i[1:0]);
  assign ctrl_wr = reg_wr_i & ~is_slot & (reg_sel == REG_CTRL);
  assign stat_wr = reg_wr_i & ~is_slot & (reg_sel == REG_STAT);
  assign slot_rd = reg_rd_i & is_slot;
  assign unused_wdata = ^reg_wdata_i;

  spi_rx_shift #(.WORD_W(WORD_W), .STAGES(SYNC_STG)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_i    (sclk_i),
    .cs_ni     (cs_ni),
    .mosi_i    (mosi_i),
    .word_vld_o(word_vld),
    .word_o    (word)
  );

  spi_rx_slots #(.WORD_W(WORD_W), .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_slots (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (grp_en),
    .start_i    (start_idx),
    .end_i      (end_idx),
    .wr_i       (word_vld),
    .wdata_i    (word),
    .rd_i       (slot_rd),
    .rd_idx_i   (reg_addr_i[IDX_W-1:0]),
    .clr_done_i (stat_wr & reg_wdata_i[STAT_DONE_BIT]),
    .clr_ovr_i  (stat_wr & reg_wdata_i[STAT_OVR_BIT]),
    .rdata_o    (slot_rdata),
    .empty_o    (empty_map),
    .ptr_o      (cur_ptr),
    .done_o     (irq_done_o),
    .ovr_o      (irq_ovr_o),
    .last_fill_o(last_fill)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_en    <= 1'b0;
      one_shot  <= 1'b0;
      start_idx <= '0;
      end_idx   <= '0;
    end else if (ctrl_wr) begin
      grp_en    <= reg_wdata_i[CTRL_EN_BIT];
      one_shot  <= reg_wdata_i[CTRL_OS_BIT];
      start_idx <= reg_wdata_i[CTRL_START_LSB +: IDX_W];
      end_idx   <= reg_wdata_i[CTRL_END_LSB +: IDX_W];
    end else if (last_fill && one_shot) begin
      grp_en <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (is_slot) begin
      reg_rdata_o[WORD_W-1:0] = slot_rdata;
    end else begin
      unique case (reg_sel)
        REG_CTRL: begin
          reg_rdata_o[CTRL_EN_BIT]               = grp_en;
          reg_rdata_o[CTRL_OS_BIT]               = one_shot;
          reg_rdata_o[CTRL_START_LSB +: IDX_W]   = start_idx;
          reg_rdata_o[CTRL_END_LSB +: IDX_W]     = end_idx;
        end
        REG_STAT: begin
          reg_rdata_o[STAT_DONE_BIT]             = irq_done_o;
          reg_rdata_o[STAT_OVR_BIT]              = irq_ovr_o;
          reg_rdata_o[STAT_PTR_LSB +: IDX_W]     = cur_ptr;
        end
        REG_EMPTY: reg_rdata_o[NUM_SLOTS-1:0]    = empty_map;
        default:   reg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_rx_group_chk.sv
module spi_rx_group_chk #(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned IDX_W     = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             word_vld,
  input logic             grp_en,
  input logic             one_shot,
  input logic             ctrl_wr,
  input logic [IDX_W-1:0] start_idx,
  input logic [IDX_W-1:0] end_idx,
  input logic [IDX_W-1:0] cur_ptr,
  input logic             irq_done_o,
  input logic             irq_ovr_o
);
  logic [IDX_W-1:0] ptr_inc;
  assign ptr_inc = (cur_ptr == IDX_W'(NUM_SLOTS-1)) ? '0 : cur_ptr + 1'b1;

  p_single_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld |=> !word_vld);

  p_ptr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld && grp_en) |=>
      cur_ptr == (($past(cur_ptr) == $past(end_idx)) ? $past(start_idx) : $past(ptr_inc)));

  p_done_source_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_done_o) |-> $past(word_vld && grp_en && cur_ptr == end_idx));

  p_ovr_source_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_ovr_o) |-> $past(word_vld && grp_en));

  p_oneshot_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld && grp_en && one_shot && cur_ptr == end_idx && !ctrl_wr) |=> !grp_en);

  p_idle_ptr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!grp_en && !ctrl_wr) |=> cur_ptr == start_idx);
endmodule

bind spi_rx_group spi_rx_group_chk #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .word_vld  (word_vld),
  .grp_en    (grp_en),
  .one_shot  (one_shot),
  .ctrl_wr   (ctrl_wr),
  .start_idx (start_idx),
  .end_idx   (end_idx),
  .cur_ptr   (cur_ptr),
  .irq_done_o(irq_done_o),
  .irq_ovr_o (irq_ovr_o)
);

// File: tb/tb_spi_rx_group.sv
module tb_spi_rx_group;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 4 * CLK_PERIOD;
  localparam int VEC_N      = 6;

  // {word, expected ptr, expected done, expected ovr}; group = slots 2..5
  localparam logic [12:0] VEC [VEC_N] = '{
    {8'hA0, 3'd3, 1'b0, 1'b0},
    {8'hA1, 3'd4, 1'b0, 1'b0},
    {8'hA2, 3'd5, 1'b0, 1'b0},
    {8'hA3, 3'd2, 1'b1, 1'b0},
    {8'hA4, 3'd3, 1'b1, 1'b1},
    {8'hA5, 3'd4, 1'b1, 1'b1}
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        sclk_i = 1'b0, cs_ni = 1'b1, mosi_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic        reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        irq_done_o, irq_ovr_o;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;
  logic [15:0] rd;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  spi_rx_group dut (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .mosi_i,
    .reg_addr_i, .reg_wr_i, .reg_rd_i, .reg_wdata_i, .reg_rdata_o,
    .irq_done_o, .irq_ovr_o
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic spi_send(input logic [7:0] w, input int nbits);
    cs_ni = 1'b0;
    #(HALF_SCK);
    for (int i = 0; i < nbits; i++) begin
      mosi_i = w[7-i];
      #(HALF_SCK); sclk_i = 1'b1;
      #(HALF_SCK); sclk_i = 1'b0;
    end
    #(HALF_SCK);
    cs_ni = 1'b1;
    #(10*CLK_PERIOD);
  endtask

  task automatic cpu_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic cpu_read(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_rd_i = 1'b1;
    #1 d = reg_rdata_o;
    @(negedge clk_i);
    reg_rd_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #(3*CLK_PERIOD) rst_ni = 1'b1;
    #(2*CLK_PERIOD);

    // R1 reset state
    cpu_read(4'd0, rd); check("R1 ctrl", rd, 16'h0000);
    cpu_read(4'd1, rd); check("R1 stat", rd, 16'h0000);
    cpu_read(4'd2, rd); check("R1 empty", rd, 16'h00FF);
    check("R1 irq", {14'd0, irq_done_o, irq_ovr_o}, 16'h0);

    // R9 disabled group discards words
    spi_send(8'h77, 8);
    cpu_read(4'd2, rd); check("R9 empty while off", rd, 16'h00FF);
    cpu_read(4'd1, rd); check("R9 stat while off", rd, 16'h0000);

    // configure slots 2..5, then enable
    cpu_write(4'd0, 16'h0520);
    cpu_write(4'd0, 16'h0521);
    cpu_read(4'd0, rd); check("R11 ctrl readback", rd, 16'h0521);
    cpu_read(4'd1, rd); check("R9 ptr at start", rd, 16'h0020);

    // R3 R5 R6 vector walk
    for (int v = 0; v < VEC_N; v++) begin
      spi_send(VEC[v][12:5], 8);
      cpu_read(4'd1, rd);
      check("R3/R5/R6 stat", rd, {9'd0, VEC[v][4:2], 2'b00, VEC[v][0], VEC[v][1]});
    end
    check("R5 irq_done_o", {15'd0, irq_done_o}, 16'h1);
    check("R6 irq_ovr_o", {15'd0, irq_ovr_o}, 16'h1);
    cpu_read(4'd2, rd); check("R4 empty after fill", rd, 16'h00C3);

    // R2 R6 slot contents (second pass overwrote slots 2,3)
    cpu_read(4'd10, rd); check("R6 slot2", rd, 16'h00A4);
    cpu_read(4'd11, rd); check("R6 slot3", rd, 16'h00A5);
    cpu_read(4'd12, rd); check("R2 slot4", rd, 16'h00A2);
    cpu_read(4'd13, rd); check("R2 slot5", rd, 16'h00A3);
    cpu_read(4'd2, rd);  check("R4 empty after reads", rd, 16'h00FF);

    // R7 write-one-to-clear
    cpu_write(4'd1, 16'h0001);
    cpu_read(4'd1, rd); check("R7 clear done", rd, 16'h0042);
    cpu_write(4'd1, 16'h0002);
    cpu_read(4'd1, rd); check("R7 clear ovr", rd, 16'h0040);
    check("R7 irq low", {14'd0, irq_done_o, irq_ovr_o}, 16'h0);

    // R10 aborted frame
    spi_send(8'h5A, 5);
    cpu_read(4'd1, rd); check("R10 ptr unchanged", rd, 16'h0040);
    cpu_read(4'd2, rd); check("R10 empty unchanged", rd, 16'h00FF);
    spi_send(8'h3C, 8);
    cpu_read(4'd1, rd); check("R10 next word stored", rd, 16'h0050);
    cpu_read(4'd12, rd); check("R10 word aligned", rd, 16'h003C);

    // R9 disable / enable returns to start
    cpu_write(4'd0, 16'h0520);
    cpu_write(4'd0, 16'h0521);
    cpu_read(4'd1, rd); check("R9 ptr reset", rd, 16'h0020);

    // R8 one-shot on slots 0..1
    cpu_write(4'd0, 16'h0100);
    cpu_write(4'd0, 16'h0103);
    cpu_read(4'd1, rd); check("R9 ptr at new start", rd, 16'h0000);
    spi_send(8'h11, 8);
    spi_send(8'h22, 8);
    cpu_read(4'd0, rd); check("R8 enable cleared", rd, 16'h0102);
    cpu_read(4'd1, rd); check("R8 stat after fill", rd, 16'h0001);
    spi_send(8'h33, 8);
    cpu_read(4'd1, rd); check("R8 discard stat", rd, 16'h0001);
    cpu_read(4'd2, rd); check("R8 discard empty", rd, 16'h00FC);
    cpu_read(4'd8, rd); check("R8 slot0 kept", rd, 16'h0011);
    cpu_read(4'd9, rd); check("R8 slot1 kept", rd, 16'h0022);

    finish_run();
  end
endmodule